// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block turns one block load or block store instruction into a stream of single-word memory transfers. A 32-bit instruction word and the current value of its pointer register are presented on a command handshake. The block decodes the 16-bit register list, works out the first address from the addressing mode, and then issues one transfer per accepted cycle. Each transfer carries the register number, the byte address and the direction.

When the list is exhausted, the block raises a one-cycle completion pulse. The pulse carries the pointer-register writeback, if one was requested, and two control flags. The first flag asks for the current status word to be reloaded from the saved copy. The second tells the register file to use the user-mode bank. Memory, the register file and bank selection sit outside the block.

Top module: `blk_xfer_seq`

## Requirements
- R1: Each set bit i of the register list (instruction bits 15:0) yields exactly one transfer naming register i. Registers are issued in ascending register-number order.
- R2: Successive transfers of one instruction use addresses that rise by 4. The lowest-numbered register gets the lowest address.
- R3: The first address depends on bit 23 (U, 1 = increment) and bit 24 (P, 1 = pointer moves before the access). With base B and n selected registers, it is B for U=1,P=0; B+4 for U=1,P=1; B-4n+4 for U=0,P=0; and B-4n for U=0,P=1. Address arithmetic is modulo 2^32.
- R4: When bit 21 is 1 and the list is non-empty, the completion pulse requests writeback. The target is the register named by bits 19:16, and the value is B+4n for U=1 or B-4n for U=0. When bit 21 is 0, or the list is empty, no writeback is requested.
- R5: The transfer direction output is 1 (load, memory to register) when bit 20 is 1, and 0 (store) otherwise.
- R6: Status restore is flagged on completion exactly when bit 22 is 1, bit 20 is 1 and list bit 15 is 1.
- R7: The user-bank flag is 1 whenever bit 22 is 1 and the status-restore condition of R6 is false. It is shown both on every transfer and on completion.
- R8: While a transfer is offered and not accepted, its register number and address hold steady. Each accepted cycle consumes exactly one register.
- R9: An empty register list produces no transfers, and completion is flagged in the cycle right after the command is accepted.
- R10: Commands are accepted only while idle. The command-ready output is low from acceptance through the completion pulse, and a command offered while busy has no effect. The completion pulse lasts one cycle, and the block is idle again in the next cycle.
- R11: After reset, the block is idle: command-ready is high, and no transfer or completion is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Instruction offered |
| cmd_ready | output | 1 | Block idle, instruction taken when valid |
| cmd_instr | input | 32 | Instruction word |
| cmd_base | input | 32 | Current pointer-register value |
| xfer_valid | output | 1 | Transfer offered |
| xfer_ready | input | 1 | Transfer taken this cycle |
| xfer_reg | output | 4 | Register number of the transfer |
| xfer_addr | output | 32 | Byte address of the transfer |
| xfer_load | output | 1 | 1 = load, 0 = store |
| xfer_user_bank | output | 1 | Use user-mode register bank |
| done | output | 1 | One-cycle completion pulse |
| done_wb_en | output | 1 | Pointer writeback requested |
| done_wb_reg | output | 4 | Pointer register number |
| done_wb_value | output | 32 | Pointer writeback value |
| done_psr_restore | output | 1 | Reload status from saved status |
| done_user_bank | output | 1 | User-bank flag at completion |

## Verification
A corrupted remaining-register mask shows up at the ports within one accepted transfer. A bit that is not cleared repeats a register number. A bit that is lost drops a register, which shortens the sequence and brings completion too early. A wrong start address or step shows on the first or second offered transfer. A stale mode, direction or flag register is visible on every transfer and on the completion pulse. The bench compares each offered transfer and each completion against a model built from the instruction fields. It uses random back-pressure so that both held and consumed cycles occur.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
    localparam int INSTR_W    = 32;
    localparam int BIT_P      = 24;
    localparam int BIT_U      = 23;
    localparam int BIT_S      = 22;
    localparam int BIT_W      = 21;
    localparam int BIT_L      = 20;
    localparam int PTR_LSB    = 16;
    localparam int WORD_BYTES = 4;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_BUSY = 2'd1,
        SQ_FIN  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/bx_lowbit.sv
module bx_lowbit #(
    parameter int N     = 16,
    localparam int IDXW = $clog2(N)
) (
    input  logic [N-1:0]    vec,
    output logic [N-1:0]    onehot,
    output logic [IDXW-1:0] idx,
    output logic            any
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar gi = 0; gi < N; gi++) begin : g_chain
        assign seen[gi+1]  = seen[gi] | vec[gi];
        assign onehot[gi]  = vec[gi] & ~seen[gi];
    end

    assign any = seen[N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) idx = idx | IDXW'(i);
        end
    end

    always_comb begin
        if (any) begin
            lowbit_single_chk: assert ($countones(onehot) == 1);
        end
    end
endmodule

// File: rtl/bx_decode.sv
module bx_decode
    import blk_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16,
    localparam int IDXW  = $clog2(NREG),
    localparam int CNTW  = $clog2(NREG + 1)
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [ADDR_W-1:0]  base,
    output logic [NREG-1:0]    list,
    output logic [ADDR_W-1:0]  start_addr,
    output logic [ADDR_W-1:0]  wb_value,
    output logic [IDXW-1:0]    wb_reg,
    output logic               wb_en,
    output logic               load,
    output logic               psr_restore,
    output logic               user_bank
);
    logic [CNTW-1:0]   count;
    logic [ADDR_W-1:0] span;
    logic              pre, up;

    always_comb begin
        count = '0;
        for (int i = 0; i < NREG; i++) count = count + CNTW'(instr[i]);
    end

    assign list   = instr[NREG-1:0];
    assign pre    = instr[BIT_P];
    assign up     = instr[BIT_U];
    assign load   = instr[BIT_L];
    assign wb_reg = instr[PTR_LSB +: IDXW];
    assign span   = ADDR_W'(count) * ADDR_W'(WORD_BYTES);

    always_comb begin
        unique case ({up, pre})
            2'b10:   start_addr = base;
            2'b11:   start_addr = base + ADDR_W'(WORD_BYTES);
            2'b00:   start_addr = base - span + ADDR_W'(WORD_BYTES);
            default: start_addr = base - span;
        endcase
        wb_value = up ? (base + span) : (base - span);
    end

    assign wb_en       = instr[BIT_W] & (count != '0);
    assign psr_restore = instr[BIT_S] & load & list[NREG-1];
    assign user_bank   = instr[BIT_S] & ~psr_restore;
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
    import blk_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16,
    localparam int IDXW  = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [INSTR_W-1:0] cmd_instr,
    input  logic [ADDR_W-1:0]  cmd_base,
    output logic               xfer_valid,
    input  logic               xfer_ready,
    output logic [IDXW-1:0]    xfer_reg,
    output logic [ADDR_W-1:0]  xfer_addr,
    output logic               xfer_load,
    output logic               xfer_user_bank,
    output logic               done,
    output logic               done_wb_en,
    output logic [IDXW-1:0]    done_wb_reg,
    output logic [ADDR_W-1:0]  done_wb_value,
    output logic               done_psr_restore,
    output logic               done_user_bank
);
    typedef struct packed {
        seq_state_e        state;
        logic [NREG-1:0]   rem;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] wb_value;
        logic [IDXW-1:0]   wb_reg;
        logic              wb_en;
        logic              load;
        logic              psr;
        logic              user;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [NREG-1:0]   dec_list;
    logic [ADDR_W-1:0] dec_start, dec_wb_value;
    logic [IDXW-1:0]   dec_wb_reg;
    logic              dec_wb_en, dec_load, dec_psr, dec_user;
    logic [NREG-1:0]   pick_onehot;
    logic [IDXW-1:0]   pick_idx;
    logic              pick_any;

    bx_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) i_decode (
        .instr       (cmd_instr),
        .base        (cmd_base),
        .list        (dec_list),
        .start_addr  (dec_start),
        .wb_value    (dec_wb_value),
        .wb_reg      (dec_wb_reg),
        .wb_en       (dec_wb_en),
        .load        (dec_load),
        .psr_restore (dec_psr),
        .user_bank   (dec_user)
    );

    bx_lowbit #(.N(NREG)) i_pick (
        .vec    (seq_q.rem),
        .onehot (pick_onehot),
        .idx    (pick_idx),
        .any    (pick_any)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            SQ_IDLE: begin
                if (cmd_valid) begin
                    seq_d.rem      = dec_list;
                    seq_d.addr     = dec_start;
                    seq_d.wb_value = dec_wb_value;
                    seq_d.wb_reg   = dec_wb_reg;
                    seq_d.wb_en    = dec_wb_en;
                    seq_d.load     = dec_load;
                    seq_d.psr      = dec_psr;
                    seq_d.user     = dec_user;
                    seq_d.state    = (dec_list == '0) ? SQ_FIN : SQ_BUSY;
                end
            end
            SQ_BUSY: begin
                if (xfer_ready) begin
                    seq_d.rem  = seq_q.rem & ~pick_onehot;
                    seq_d.addr = seq_q.addr + ADDR_W'(WORD_BYTES);
                    if (seq_d.rem == '0) seq_d.state = SQ_FIN;
                end
            end
            default: begin
                seq_d.state = SQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{state: SQ_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cmd_ready        = (seq_q.state == SQ_IDLE);
    assign xfer_valid       = (seq_q.state == SQ_BUSY) && pick_any;
    assign xfer_reg         = pick_idx;
    assign xfer_addr        = seq_q.addr;
    assign xfer_load        = seq_q.load;
    assign xfer_user_bank   = seq_q.user;
    assign done             = (seq_q.state == SQ_FIN);
    assign done_wb_en       = done && seq_q.wb_en;
    assign done_wb_reg      = seq_q.wb_reg;
    assign done_wb_value    = seq_q.wb_value;
    assign done_psr_restore = done && seq_q.psr;
    assign done_user_bank   = done && seq_q.user;

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_reg) && $stable(xfer_addr)));

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_ready) |=> (!xfer_valid || xfer_addr == $past(xfer_addr) + ADDR_W'(WORD_BYTES)));

    // R1
    reg_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_ready) |=> (!xfer_valid || xfer_reg > $past(xfer_reg)));

    // R9
    empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_instr[NREG-1:0] == '0) |=> (done && !xfer_valid));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cmd_ready));

    // R10
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_instr[NREG-1:0] != '0) |=> (!cmd_ready && xfer_valid));
endmodule

// File: tb/test_blk_xfer_seq.sv
module test_blk_xfer_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_instr = '0;
    logic [31:0] cmd_base = '0;
    logic        xfer_valid;
    logic        xfer_ready = 1'b0;
    logic [3:0]  xfer_reg;
    logic [31:0] xfer_addr;
    logic        xfer_load, xfer_user_bank;
    logic        done, done_wb_en, done_psr_restore, done_user_bank;
    logic [3:0]  done_wb_reg;
    logic [31:0] done_wb_value;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    blk_xfer_seq i_blk_xfer_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_instr(cmd_instr), .cmd_base(cmd_base),
        .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
        .xfer_reg(xfer_reg), .xfer_addr(xfer_addr),
        .xfer_load(xfer_load), .xfer_user_bank(xfer_user_bank),
        .done(done), .done_wb_en(done_wb_en), .done_wb_reg(done_wb_reg),
        .done_wb_value(done_wb_value), .done_psr_restore(done_psr_restore),
        .done_user_bank(done_user_bank)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int popc(input logic [15:0] l);
        int n = 0;
        for (int i = 0; i < 16; i++) n += l[i];
        return n;
    endfunction

    function automatic logic [31:0] first_addr(input logic [31:0] ins, input logic [31:0] b);
        logic [31:0] span = 32'(popc(ins[15:0]) * 4);
        case ({ins[23], ins[24]})
            2'b10:   return b;
            2'b11:   return b + 32'd4;
            2'b00:   return b - span + 32'd4;
            default: return b - span;
        endcase
    endfunction

    task automatic run(input logic [31:0] ins, input logic [31:0] b, input bit poke_busy);
        logic [15:0] lst = ins[15:0];
        int n = popc(lst);
        logic [31:0] a0 = first_addr(ins, b);
        logic [31:0] span = 32'(n * 4);
        bit exp_psr = ins[22] && ins[20] && lst[15];
        bit exp_user = ins[22] && !exp_psr;
        int exp_reg[16];
        int k = 0;
        int idx = 0;
        int cyc = 0;
        bit poked = 0;
        for (int i = 0; i < 16; i++) if (lst[i]) begin exp_reg[k] = i; k++; end
        @(negedge clk);
        check(cmd_ready == 1'b1, "R10 ready when idle", 32'(cmd_ready), 32'd1);
        cmd_instr = ins; cmd_base = b; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (n == 0) begin
            check(done == 1'b1 && xfer_valid == 1'b0, "R9 empty list done next cycle",
                  {30'd0, done, xfer_valid}, 32'd2);
        end
        forever begin
            if (done) break;
            cyc++;
            if (cyc > 200) begin
                check(1'b0, "R10 no completion", 32'(idx), 32'(n));
                return;
            end
            if (poke_busy && poked && cmd_valid) cmd_valid = 1'b0;
            if (xfer_valid) begin
                check(idx < n, "R1 extra transfer", 32'(idx), 32'(n));
                if (idx < n) begin
                    check(xfer_reg == exp_reg[idx][3:0], "R1 register order", 32'(xfer_reg), 32'(exp_reg[idx]));
                    check(xfer_addr == a0 + 32'(idx * 4), (idx == 0) ? "R3 start address" : "R2 address step",
                          xfer_addr, a0 + 32'(idx * 4));
                end
                check(xfer_load == ins[20], "R5 direction", 32'(xfer_load), 32'(ins[20]));
                check(xfer_user_bank == exp_user, "R7 user bank on transfer", 32'(xfer_user_bank), 32'(exp_user));
                check(cmd_ready == 1'b0, "R10 not ready while busy", 32'(cmd_ready), 32'd0);
            end
            if (poke_busy && !poked && xfer_valid) begin
                poked = 1;
                cmd_valid = 1'b1;
                cmd_instr = ~ins;
                cmd_base = ~b;
                xfer_ready = 1'b0;
            end else begin
                xfer_ready = ($urandom % 3) != 0;
            end
            if (xfer_valid && xfer_ready) idx++;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        xfer_ready = 1'b0;
        check(idx == n, "R1 transfer count", 32'(idx), 32'(n));
        check(done_wb_en == (ins[21] && n != 0), "R4 writeback enable", 32'(done_wb_en), 32'(ins[21] && n != 0));
        if (ins[21] && n != 0) begin
            check(done_wb_reg == ins[19:16], "R4 writeback register", 32'(done_wb_reg), 32'(ins[19:16]));
            check(done_wb_value == (ins[23] ? b + span : b - span), "R4 writeback value",
                  done_wb_value, ins[23] ? b + span : b - span);
        end
        check(done_psr_restore == exp_psr, "R6 status restore", 32'(done_psr_restore), 32'(exp_psr));
        check(done_user_bank == exp_user, "R7 user bank on done", 32'(done_user_bank), 32'(exp_user));
        @(negedge clk);
        check(done == 1'b0 && cmd_ready == 1'b1, "R10 single-cycle done", {30'd0, done, cmd_ready}, 32'd1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(cmd_ready == 1'b1 && xfer_valid == 1'b0 && done == 1'b0, "R11 reset state",
              {29'd0, cmd_ready, xfer_valid, done}, 32'd4);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready == 1'b1 && xfer_valid == 1'b0 && done == 1'b0, "R11 idle after reset",
              {29'd0, cmd_ready, xfer_valid, done}, 32'd4);
        // directed: each of the four modes, with and without writeback
        run({7'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3, 16'h00F0}, 32'h0000_1000, 0);
        run({7'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd5, 16'h8421}, 32'h0000_2000, 0);
        run({7'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd13, 16'h0306}, 32'h0000_3000, 0);
        run({7'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 16'hFFFF}, 32'h0000_0010, 0);
        // empty list with writeback requested
        run({7'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd2, 16'h0000}, 32'h0000_4000, 0);
        // status restore: load with r15 and S set; store with S set
        run({7'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd1, 16'h8001}, 32'h0000_5000, 0);
        run({7'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1, 16'h8001}, 32'h0000_5000, 0);
        run({7'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd1, 16'h4001}, 32'h0000_5000, 0);
        // decrement below zero wraps
        run({7'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd9, 16'h0C00}, 32'h0000_0004, 0);
        // command offered while busy is ignored
        run({7'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd7, 16'h1111}, 32'h0001_0000, 1);
        for (int t = 0; t < 150; t++) begin
            logic [31:0] ins = $urandom;
            if ((t % 4) == 0) ins[15:0] = ins[15:0] & $urandom & $urandom;
            run(ins, $urandom, (t % 10) == 3 && popc(ins[15:0]) >= 2);
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule